// File: doc/BRIEF.md
# Two-Bank Interrupt Pending Register with Set/Clear Modify Port

This block collects 128 interrupt levels for one node of a multiprocessor and presents them to the local processor as two summary lines. The levels are held in two 64-bit pending banks. Level numbers 0 to 63 land in bank 0 at the same bit position. Level numbers 64 to 127 land in bank 1 at bit position level minus 64. Each bank also has a 64-bit enable mask. A registered summary output is high when any pending bit of the bank is also enabled. Bank 0 drives processor interrupt level 2 and bank 1 drives processor interrupt level 3.

Software never writes a pending bank directly. It writes one encoded word to a write-only modify register. The low seven bits of that word select the level, and bit 8 selects whether the level is set or cleared. Hardware sources raise levels through a 128-bit set-pulse input, and a pulse always wins over a software clear of the same bit in the same cycle. A read of a pending bank in the cycle after a modify write already returns the new contents. Software relies on this to confirm that a clear has landed.

Top module: `irq_pend_hub`

## Requirements
- R1: While reset is asserted and right after it, all pending bits, all enable bits, both summary outputs and the read data are 0.
- R2: A write to offset 0x0 with data bit 8 = 1 sets the level in data bits 6:0. Levels below 64 set bank 0 bit `level`, and levels 64 and above set bank 1 bit `level-64`. No other bit changes.
- R3: A write to offset 0x0 with data bit 8 = 0 clears the addressed level (same mapping as R2) and leaves every other pending bit unchanged.
- R4: Data bit 7 and data bits 63:9 of a modify write have no effect on which level is touched or on whether it is set or cleared.
- R5: A high bit n of `hw_set_i` sets pending level n (same mapping as R2) at the next clock edge. If a software clear of the same level arrives in the same cycle, the level ends up set.
- R6: Reads use offsets 0x8 (bank 0 pending), 0x10 (bank 1 pending), 0x18 (bank 0 enable) and 0x20 (bank 1 enable). The data appears on `reg_rdata_o` one cycle after `reg_rd_i`, and a read issued in the cycle after a modify write returns the updated state.
- R7: Writes to offsets 0x8 and 0x10 leave both pending banks unchanged.
- R8: A write to offset 0x18 or 0x20 loads the whole 64-bit enable mask of bank 0 or bank 1.
- R9: `irq_l2_o` equals the OR of (bank 0 pending AND bank 0 enable) one cycle after that value, and `irq_l3_o` does the same for bank 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 6 | Byte offset of the register |
| reg_wdata_i | input | 64 | Write data |
| reg_rdata_o | output | 64 | Read data, valid the cycle after the read strobe |
| hw_set_i | input | 128 | Hardware set pulse, one per level |
| irq_l2_o | output | 1 | Registered summary of bank 0 |
| irq_l3_o | output | 1 | Registered summary of bank 1 |

## Verification
The bench sweeps all 128 levels through a set and a clear, with junk in data bit 7 and the upper data bits. A design that used eight level bits, or that mapped levels 64 and up onto the wrong bank or bit, would leave the wrong bit set or would drive the wrong summary line. It collides a hardware set pulse with a software clear of the same level, and a design that let the clear win would lose that interrupt. It writes all ones to the pending offsets, reads back immediately after modify writes, and checks each summary line under partial enable masks. A design that accepted direct pending writes, read stale data, or ignored the mask would show a mismatch at the read port or on the summary line.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;
    parameter int NUM_BANKS     = 2;
    parameter int LVLS_PER_BANK = 64;
    parameter int DATA_W        = 64;
    parameter int ADDR_W        = 6;
    parameter int SET_FLAG_BIT  = 8;
    localparam int TOTAL_LVLS   = NUM_BANKS * LVLS_PER_BANK;
    localparam int LVL_W        = $clog2(TOTAL_LVLS);
    localparam int WORD_SHIFT   = 3;
endpackage

// File: rtl/irq_mod_decode.sv
module irq_mod_decode
    import irq_pend_pkg::*;
#(
    parameter int NB   = NUM_BANKS,
    parameter int W    = LVLS_PER_BANK,
    parameter int DW   = DATA_W,
    parameter int FLAG = SET_FLAG_BIT
) (
    input  logic            mod_we_i,
    input  logic [DW-1:0]   wdata_i,
    output logic [NB*W-1:0] set_o,
    output logic [NB*W-1:0] clr_o
);
    localparam int LW = $clog2(NB*W);

    logic [LW-1:0] lvl;
    logic          unused_bits;

    assign lvl         = wdata_i[LW-1:0];
    assign unused_bits = ^{wdata_i[DW-1:FLAG+1], wdata_i[FLAG-1:LW]};

    always_comb begin
        set_o = '0;
        clr_o = '0;
        if (mod_we_i) begin
            if (wdata_i[FLAG]) set_o[lvl] = 1'b1;
            else               clr_o[lvl] = 1'b1;
        end
    end
endmodule

// File: rtl/irq_pend_bank.sv
module irq_pend_bank
    import irq_pend_pkg::*;
#(
    parameter int W = LVLS_PER_BANK
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    input  logic [W-1:0] hw_set_i,
    input  logic         en_we_i,
    input  logic [W-1:0] en_wdata_i,
    output logic [W-1:0] pend_o,
    output logic [W-1:0] en_o,
    output logic         irq_o
);
    typedef struct packed {
        logic [W-1:0] pend;
        logic [W-1:0] en;
        logic         irq;
    } bank_st_t;

    bank_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // sets are ORed after the clear so a set always wins
        st_d.pend = (st_q.pend & ~clr_i) | set_i | hw_set_i;
        if (en_we_i) st_d.en = en_wdata_i;
        st_d.irq  = |(st_q.pend & st_q.en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend_o = st_q.pend;
    assign en_o   = st_q.en;
    assign irq_o  = st_q.irq;

    // R5
    hw_set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_set_i != '0) |=> ((pend_o & $past(hw_set_i)) == $past(hw_set_i)));

    // R3
    clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((pend_o & $past(clr_i & ~set_i & ~hw_set_i)) == '0));

    // R9
    summary_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o & en_o) != '0) |=> irq_o);

    // R9
    summary_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_o & en_o) == '0) |=> !irq_o);
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
    import irq_pend_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int W  = LVLS_PER_BANK,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_i,
    input  logic            rd_i,
    input  logic [AW-1:0]   addr_i,
    input  logic [NB*W-1:0] pend_i,
    input  logic [NB*W-1:0] en_i,
    output logic            mod_we_o,
    output logic [NB-1:0]   en_we_o,
    output logic [DW-1:0]   rdata_o
);
    localparam int IDX_W = AW - WORD_SHIFT;

    typedef struct packed {
        logic [DW-1:0] rdata;
    } port_st_t;

    port_st_t             st_d, st_q;
    logic [IDX_W-1:0]     idx;
    logic                 aligned;

    assign idx     = addr_i[AW-1:WORD_SHIFT];
    assign aligned = (addr_i[WORD_SHIFT-1:0] == '0);

    always_comb begin
        mod_we_o = wr_i && aligned && (idx == '0);
        en_we_o  = '0;
        for (int b = 0; b < NB; b++) begin
            if (wr_i && aligned && (idx == IDX_W'(1 + NB + b))) en_we_o[b] = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        if (rd_i) begin
            st_d.rdata = '0;
            if (aligned) begin
                for (int b = 0; b < NB; b++) begin
                    if (idx == IDX_W'(1 + b))      st_d.rdata = DW'(pend_i[b*W +: W]);
                    if (idx == IDX_W'(1 + NB + b)) st_d.rdata = DW'(en_i[b*W +: W]);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rdata_o = st_q.rdata;

    // R6
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_i |=> $stable(rdata_o));
endmodule

// File: rtl/irq_pend_hub.sv
module irq_pend_hub
    import irq_pend_pkg::*;
#(
    parameter int NB = NUM_BANKS,
    parameter int W  = LVLS_PER_BANK,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_wr_i,
    input  logic            reg_rd_i,
    input  logic [AW-1:0]   reg_addr_i,
    input  logic [DW-1:0]   reg_wdata_i,
    output logic [DW-1:0]   reg_rdata_o,
    input  logic [NB*W-1:0] hw_set_i,
    output logic            irq_l2_o,
    output logic            irq_l3_o
);
    logic            mod_we;
    logic [NB-1:0]   en_we;
    logic [NB*W-1:0] sw_set, sw_clr, pend_all, en_all;
    logic [NB-1:0]   irq_all;

    irq_mod_decode #(.NB(NB), .W(W), .DW(DW), .FLAG(SET_FLAG_BIT)) u_decode (
        .mod_we_i (mod_we),
        .wdata_i  (reg_wdata_i),
        .set_o    (sw_set),
        .clr_o    (sw_clr)
    );

    irq_reg_port #(.NB(NB), .W(W), .DW(DW), .AW(AW)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (reg_wr_i),
        .rd_i     (reg_rd_i),
        .addr_i   (reg_addr_i),
        .pend_i   (pend_all),
        .en_i     (en_all),
        .mod_we_o (mod_we),
        .en_we_o  (en_we),
        .rdata_o  (reg_rdata_o)
    );

    for (genvar b = 0; b < NB; b++) begin : g_bank
        irq_pend_bank #(.W(W)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .set_i      (sw_set[b*W +: W]),
            .clr_i      (sw_clr[b*W +: W]),
            .hw_set_i   (hw_set_i[b*W +: W]),
            .en_we_i    (en_we[b]),
            .en_wdata_i (reg_wdata_i[W-1:0]),
            .pend_o     (pend_all[b*W +: W]),
            .en_o       (en_all[b*W +: W]),
            .irq_o      (irq_all[b])
        );
    end

    assign irq_l2_o = irq_all[0];
    assign irq_l3_o = irq_all[NB-1];

    // R2
    one_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sw_set | sw_clr));

    // R7
    no_direct_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_i && (reg_addr_i == AW'(8) || reg_addr_i == AW'(16)) && hw_set_i == '0)
        |=> (pend_all == $past(pend_all)));
endmodule

// File: tb/tb_irq_pend_hub.sv
module tb_irq_pend_hub;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         reg_wr_i, reg_rd_i;
    logic [5:0]   reg_addr_i;
    logic [63:0]  reg_wdata_i, reg_rdata_o;
    logic [127:0] hw_set_i;
    logic         irq_l2_o, irq_l3_o;

    int checks = 0;
    int fails  = 0;
    logic [127:0] model;
    logic [63:0]  en0m, en1m, rd;

    always #2.5 clk = ~clk;

    irq_pend_hub dut (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [63:0] d, input logic [127:0] hw);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d; hw_set_i = hw;
        @(negedge clk);
        reg_wr_i = 1'b0; reg_wdata_i = '0; hw_set_i = '0;
    endtask

    task automatic rdreg(input logic [5:0] a, output logic [63:0] d);
        reg_rd_i = 1'b1; reg_addr_i = a;
        @(negedge clk);
        reg_rd_i = 1'b0;
        d = reg_rdata_o;
    endtask

    task automatic chk_banks(input string tag);
        rdreg(6'h08, rd); chk({tag, " bank0"}, rd, model[63:0]);
        rdreg(6'h10, rd); chk({tag, " bank1"}, rd, model[127:64]);
    endtask

    task automatic chk_irq(input string tag);
        @(negedge clk);
        chk({tag, " irq_l2"}, 64'(irq_l2_o), 64'(|(model[63:0] & en0m)));
        chk({tag, " irq_l3"}, 64'(irq_l3_o), 64'(|(model[127:64] & en1m)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; reg_wr_i = 0; reg_rd_i = 0; reg_addr_i = '0;
        reg_wdata_i = '0; hw_set_i = '0;
        model = '0; en0m = '0; en1m = '0;
        repeat (3) @(negedge clk);
        chk("R1 rdata", reg_rdata_o, 64'h0);
        chk("R1 irq", {62'h0, irq_l3_o, irq_l2_o}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk_banks("R1 reset");
        rdreg(6'h18, rd); chk("R1 en0", rd, 64'h0);
        rdreg(6'h20, rd); chk("R1 en1", rd, 64'h0);

        // R8 enable masks
        wr(6'h18, 64'hFFFF_FFFF_FFFF_FFFF, '0); en0m = '1;
        wr(6'h20, 64'hFFFF_FFFF_FFFF_FFFF, '0); en1m = '1;
        rdreg(6'h18, rd); chk("R8 en0", rd, en0m);
        rdreg(6'h20, rd); chk("R8 en1", rd, en1m);

        // R2 R3 R4 R6 R9: sweep every level with junk upper bits
        for (int lvl = 0; lvl < 128; lvl++) begin
            logic [63:0] junk;
            junk = {lvl[7:0], 8'h5A, ~lvl[7:0], 8'hC3, lvl[7:0], 8'h96, 16'h0} & ~64'h1FF;
            junk[7] = lvl[0];
            wr(6'h00, junk | 64'h100 | 64'(lvl), '0);
            model[lvl] = 1'b1;
            chk_banks("R2 R4 R6 set sweep");
            chk_irq("R9 set sweep");
            wr(6'h00, junk | 64'(lvl), '0);
            model[lvl] = 1'b0;
            chk_banks("R3 R6 clear sweep");
            chk_irq("R9 clear sweep");
        end

        // R3: clear one of several
        wr(6'h00, 64'h100 | 64'd5,   '0); model[5]   = 1;
        wr(6'h00, 64'h100 | 64'd70,  '0); model[70]  = 1;
        wr(6'h00, 64'h100 | 64'd127, '0); model[127] = 1;
        wr(6'h00, 64'd70, '0); model[70] = 0;
        chk_banks("R3 selective clear");

        // R7: direct writes to pending offsets
        wr(6'h08, 64'hFFFF_FFFF_FFFF_FFFF, '0);
        wr(6'h10, 64'hFFFF_FFFF_FFFF_FFFF, '0);
        chk_banks("R7 ignored write");

        // R5: hardware set alone, and colliding with software clear
        wr(6'h00, 64'h200, 128'(1) << 100); model[100] = 1;
        chk_banks("R5 hw set");
        wr(6'h00, 64'd100, 128'(1) << 100);
        chk_banks("R5 set beats clear");
        wr(6'h00, 64'd5, 128'(1) << 9); model[5] = 0; model[9] = 1;
        chk_banks("R5 clear and set different levels");

        // R9 R8: partial masks
        wr(6'h18, 64'h0000_0000_0000_00F0, '0); en0m = 64'hF0;
        wr(6'h20, 64'h0, '0); en1m = '0;
        rdreg(6'h18, rd); chk("R8 en0 partial", rd, en0m);
        chk_irq("R9 masked");
        wr(6'h00, 64'h100 | 64'd6, '0); model[6] = 1;
        chk_irq("R9 enabled bit");
        wr(6'h00, 64'd6, '0); model[6] = 0;
        chk_irq("R9 after clear");
        wr(6'h20, 64'h8000_0000_0000_0000, '0); en1m = 64'h8000_0000_0000_0000;
        chk_irq("R9 bank1 enable");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule